// File: doc/BRIEF.md
# Phase-Shared Trace Memory Controller

This block manages a small trace memory (1024 words of 8 bits by default) that has only one address path. Each base period is split into two halves by an internal phase signal. In the first half, the write half, an external horizontal-position code addresses the memory, and an amplitude sample may be stored at that location. In the second half, the read half, a free-running refresh counter addresses the memory, and the word at that address is captured into an output holding register.

A single-cycle `tick` input marks each half-period boundary, so everything runs in one synchronous clock domain. The refresh counter advances once per full period and wraps. The block drives a sweep-active level for a downstream horizontal ramp, and a sweep-end level that terminates that ramp. The last two counter states fall outside the visible sweep.

Top module: `trace_mem_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rd_addr` is 0, `rd_data` is 0, `phase_wr` is 1, `sweep_active` is 1 and `sweep_end` is 0.
- R2: `phase_wr` inverts on every clock edge where `tick` is high. It holds on every edge where `tick` is low. `phase_wr` = 1 marks the write half and `phase_wr` = 0 marks the read half.
- R3: `mem_addr` equals `wr_pos` while `phase_wr` is 1, and equals `rd_addr` while `phase_wr` is 0.
- R4: The memory word at `wr_pos` takes `wr_data` only on an edge where `tick`, `wr_stb` and `phase_wr` are all 1. A strobe given in the read half leaves the memory unchanged.
- R5: On an edge where `tick` is 1 and `phase_wr` is 0, `rd_data` loads the word stored at `rd_addr`, and `rd_addr` then increments by one. That word includes a write made in the write half of the same period.
- R6: `rd_addr` wraps from 1023 to 0.
- R7: `sweep_active` is 1 for `rd_addr` values 0 to 1021 and 0 for values 1022 and 1023.
- R8: `sweep_end` is 1 exactly while `rd_addr` is 1022.
- R9: `rd_data` and `rd_addr` hold their values on every edge other than a read-half tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Half-period boundary enable |
| wr_stb | input | 1 | Write request for the current write half |
| wr_pos | input | 10 | Horizontal-position write address |
| wr_data | input | 8 | Amplitude sample to store |
| phase_wr | output | 1 | 1 in the write half, 0 in the read half |
| mem_addr | output | 10 | Address currently applied to the memory |
| rd_addr | output | 10 | Refresh counter value |
| rd_data | output | 8 | Captured read word |
| sweep_active | output | 1 | Visible sweep in progress |
| sweep_end | output | 1 | End-of-sweep level for the ramp |

## Verification
The hardest case to reach is a write and a read that hit the same word in one period. A write-half sample aimed at the current refresh address must appear in `rd_data` at the next tick. A read-half strobe aimed at that same address must not appear. The stimulus often steers `wr_pos` to the bench's own copy of the refresh counter, in both halves, so both orderings occur many times. More than two thousand periods run, so the counter passes the blanked states and wraps twice.

// File: rtl/trace_mem_ctrl.sv
module trace_mem_ctrl #(
  parameter int AW    = 10,
  parameter int DW    = 8,
  parameter int BLANK = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_pos,
  input  logic [DW-1:0] wr_data,
  output logic          phase_wr,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          sweep_active,
  output logic          sweep_end
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] STOP = AW'(DEPTH - BLANK);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] cnt;
  logic          ph;
  logic [DW-1:0] latch_q;

  wire do_wr = tick & ph & wr_stb;
  wire do_rd = tick & ~ph;

  assign mem_addr     = ph ? wr_pos : cnt;
  assign phase_wr     = ph;
  assign rd_addr      = cnt;
  assign rd_data      = latch_q;
  assign sweep_active = cnt < STOP;
  assign sweep_end    = cnt == STOP;

  always_ff @(posedge clk) begin
    if (do_wr) mem[mem_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= 1'b1;
      cnt     <= '0;
      latch_q <= '0;
    end else begin
      if (tick) ph <= ~ph;
      if (do_rd) begin
        latch_q <= mem[mem_addr];
        cnt     <= cnt + 1'b1;
      end
    end
  end
endmodule

module trace_mem_ctrl_chk #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          phase_wr,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic          sweep_active,
  input logic          sweep_end
);
  localparam logic [AW-1:0] TOP = '1;

  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (rst) tick |=> phase_wr != $past(phase_wr)); // R2
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(phase_wr)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst) (tick && !phase_wr) |=> rd_addr == AW'($past(rd_addr) + 1'b1)); // R5
  AST_WRAP: assert property (@(posedge clk) disable iff (rst) (tick && !phase_wr && rd_addr == TOP) |=> (rd_addr == '0 && sweep_active)); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) !(tick && !phase_wr) |=> ($stable(rd_addr) && $stable(rd_data))); // R9
  AST_END_BLANK: assert property (@(posedge clk) disable iff (rst) sweep_end |-> !sweep_active); // R8
  AST_SWEEP_STOP: assert property (@(posedge clk) disable iff (rst) $fell(sweep_active) |-> sweep_end); // R7
  AST_RESET: assert property (@(posedge clk) rst |=> (rd_addr == '0 && rd_data == '0 && phase_wr)); // R1
endmodule

bind trace_mem_ctrl trace_mem_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .phase_wr(phase_wr), .rd_addr(rd_addr),
  .rd_data(rd_data), .sweep_active(sweep_active), .sweep_end(sweep_end)
);

// File: tb/trace_mem_ctrl_tb.sv
module trace_mem_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst = 1, tick = 0, wr_stb = 0;
  logic [AW-1:0] wr_pos = '0;
  logic [DW-1:0] wr_data = '0;
  logic phase_wr, sweep_active, sweep_end;
  logic [AW-1:0] mem_addr, rd_addr;
  logic [DW-1:0] rd_data;

  trace_mem_ctrl #(.AW(AW), .DW(DW), .BLANK(2)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_stb(wr_stb), .wr_pos(wr_pos),
    .wr_data(wr_data), .phase_wr(phase_wr), .mem_addr(mem_addr), .rd_addr(rd_addr),
    .rd_data(rd_data), .sweep_active(sweep_active), .sweep_end(sweep_end)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_ok  [DEPTH];
  int            m_cnt = 0;
  bit            m_ph = 1;
  int            m_dout = 0;
  bit            dout_known = 1;

  function automatic int exp_active(int c); return (c < DEPTH - 2) ? 1 : 0; endfunction
  function automatic int exp_end(int c);    return (c == DEPTH - 2) ? 1 : 0; endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R2 phase", int'(phase_wr), int'(m_ph));
    check("R5 R6 rd_addr", int'(rd_addr), m_cnt);
    if (dout_known) check("R5 R4 rd_data", int'(rd_data), m_dout);
    check("R7 sweep_active", int'(sweep_active), exp_active(m_cnt));
    check("R8 sweep_end", int'(sweep_end), exp_end(m_cnt));
  endtask

  task automatic half(bit stb, logic [AW-1:0] pos, logic [DW-1:0] d);
    @(negedge clk);
    wr_stb = stb; wr_pos = pos; wr_data = d; tick = 1;
    #1 check("R3 mem_addr", int'(mem_addr), m_ph ? int'(pos) : m_cnt);
    @(posedge clk);
    if (m_ph) begin
      if (stb) begin m_mem[pos] = d; m_ok[pos] = 1; end
    end else begin
      dout_known = m_ok[m_cnt];
      m_dout = int'(m_mem[m_cnt]);
      m_cnt = (m_cnt + 1) % DEPTH;
    end
    m_ph = !m_ph;
    @(negedge clk);
    tick = 0; wr_stb = 0;
    check_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_stb = $urandom_range(0, 1); wr_pos = AW'($urandom); wr_data = DW'($urandom);
      @(negedge clk);
      check_all(); // R9 R2 hold without tick
    end
    wr_stb = 0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_ok[i] = 0; m_mem[i] = '0; end
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    check("R1 rd_addr", int'(rd_addr), 0);
    check("R1 rd_data", int'(rd_data), 0);
    check("R1 phase", int'(phase_wr), 1);
    rst = 0;
    @(negedge clk);
    check("R1 after release addr", int'(rd_addr), 0);
    check("R1 sweep_active", int'(sweep_active), 1);
    check("R1 sweep_end", int'(sweep_end), 0);
    idle(3);
    // Directed: same-period write then read at address 0 (R5), then ignored read-half strobe (R4)
    half(1, AW'(0), 8'hA5);
    half(1, AW'(0), 8'h3C);
    check("R5 same-period", int'(rd_data), 8'hA5);
    half(1, AW'(1), 8'h11);
    half(1, AW'(5), 8'h77);
    check("R5 second word", int'(rd_data), 8'h11);
    for (int p = 0; p < 2200; p++) begin
      logic [AW-1:0] cur;
      cur = AW'(m_cnt);
      half($urandom_range(0, 9) != 0, ($urandom_range(0, 2) != 0) ? cur : AW'($urandom), DW'($urandom));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 2));
      half($urandom_range(0, 1) == 1, ($urandom_range(0, 1) == 1) ? cur : AW'($urandom), DW'($urandom)); // R4
      if ($urandom_range(0, 7) == 0) idle(1);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule